// File: doc/BRIEF.md
# Atomic Swap Memory Unit

This block exchanges a register value with one memory location as a single indivisible operation. A request carries an address, a value to store and a size flag (word or byte). The block first reads the location, then writes the new value to the same location, and holds a lock output high across both accesses so that the memory system can keep other masters away. When the sequence ends, it returns the old memory contents, formatted for a destination register, with a write-enable for that register.

Word loads from an address whose two low bits are not zero come back rotated right by eight bits per byte of offset. The stored word is never rotated and goes to the containing aligned word. Byte swaps read one byte, write the low byte of the store value and zero-extend the loaded byte. An abort on either access, or an alignment fault when checking is enabled, ends the operation without writing the destination register. Each outcome is reported with its own status flag.

Top module: `atomic_xchg_unit`

## Requirements
- R1: After a load that completes without abort, the store is requested in the very next cycle, at the same memory address. No store is ever issued before the load of the same swap.
- R2: In word size, `rdData` equals the loaded word rotated right by 8 × `reqAddr[1:0]` bits.
- R3: In word size, both accesses use `memByte`=0 and `memAddr` with bits [1:0] forced to 00. The store writes `reqData` without rotation.
- R4: In byte size (`reqByte`=1), both accesses use `memByte`=1 and the full address. The store drives the low byte of `reqData` in `memWdata[7:0]` with the upper bits zero. `rdData` is `memRdata[7:0]` zero-extended, whatever the upper bits of `memRdata` carry.
- R5: If the load is acknowledged with `memAbort`=1, no store is requested, `loadAbort` is 1 and `rdWe` is 0 in the completion cycle.
- R6: If the store is acknowledged with `memAbort`=1, `storeAbort` is 1 and `rdWe` is 0 in the completion cycle.
- R7: A word request with `alignCheckEn`=1 and `reqAddr[1:0]`≠00 makes no memory access and completes one cycle after acceptance with `alignFault`=1 and `rdWe`=0. Byte requests are never faulted.
- R8: `memLock` is high in every cycle in which `memReq` is high, and low at all other times.
- R9: A memory request holds its address, direction and write data until `memReady`. `reqReady` stays low from acceptance until after the completion cycle, and `reqValid` is ignored while it is low.
- R10: After reset, `reqReady`=1 and `memReq`, `memLock`, `doneValid` and `rdWe` are 0.
- R11: `doneValid` is a one-cycle pulse, one cycle after the final memory acknowledgement. `rdWe` is 1 in that cycle only when both accesses completed without abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Swap request present |
| reqReady | output | 1 | Block idle, request accepted when both are high |
| reqAddr | input | AW | Byte address of the location |
| reqData | input | DW | Value to store |
| reqByte | input | 1 | 1 = byte swap, 0 = word swap |
| alignCheckEn | input | 1 | Enable alignment fault on misaligned words |
| memReq | output | 1 | Memory access request |
| memWrite | output | 1 | 1 = store, 0 = load |
| memByte | output | 1 | 1 = byte access, 0 = word access |
| memLock | output | 1 | Keep the location locked |
| memAddr | output | AW | Access address |
| memWdata | output | DW | Store data |
| memRdata | input | DW | Load data, valid with memReady on a load |
| memReady | input | 1 | Access acknowledged |
| memAbort | input | 1 | Access aborted, valid with memReady |
| doneValid | output | 1 | Swap finished (one cycle) |
| rdWe | output | 1 | Write rdData to the destination register |
| rdData | output | DW | Formatted loaded value |
| alignFault | output | 1 | Swap refused for misalignment |
| loadAbort | output | 1 | Load access aborted |
| storeAbort | output | 1 | Store access aborted |

## Verification
The hardest case to reach is a second request arriving while a swap is still waiting on memory. That request must neither disturb the locked pair of accesses nor be silently taken once the unit becomes idle. The stimulus stretches the memory latency with injected wait states and asserts a conflicting request during the wait. The bench then confirms that the access log holds only the original address and that no extra swap follows. Aborts are injected separately on the load and on the store, so each suppression path is reached on its own.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_STORE = 2'd2,
    ST_DONE  = 2'd3
  } xchgState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureReq;     // latch request fields, clear status
    logic markFault;      // alignment fault at capture
    logic captureLoad;    // latch load data
    logic markLoadAbort;
    logic markStoreAbort;
    logic finish;         // completion cycle
  } xchgStrobe_t;

endpackage

// File: rtl/xchg_ctrl.sv
module xchg_ctrl
  import xchg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        alignCheckEn,
  input  logic        reqMisaligned,
  input  logic        memReady,
  input  logic        memAbort,
  output logic        reqReady,
  output logic        memReq,
  output logic        memWrite,
  output logic        memLock,
  output logic        doneValid,
  output xchgStrobe_t strobe
);

  xchgState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD    = stateQ;
    strobe    = '0;
    reqReady  = 1'b0;
    memReq    = 1'b0;
    memWrite  = 1'b0;
    doneValid = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.captureReq = 1'b1;
          if (alignCheckEn && reqMisaligned) begin
            strobe.markFault = 1'b1;
            stateD = ST_DONE;
          end else begin
            stateD = ST_LOAD;
          end
        end
      end
      ST_LOAD: begin
        memReq = 1'b1;
        if (memReady) begin
          if (memAbort) begin
            strobe.markLoadAbort = 1'b1;
            stateD = ST_DONE;
          end else begin
            strobe.captureLoad = 1'b1;
            stateD = ST_STORE;
          end
        end
      end
      ST_STORE: begin
        memReq   = 1'b1;
        memWrite = 1'b1;
        if (memReady) begin
          strobe.markStoreAbort = memAbort;
          stateD = ST_DONE;
        end
      end
      ST_DONE: begin
        doneValid     = 1'b1;
        strobe.finish = 1'b1;
        stateD        = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  // Lock spans the load and store phases back to back
  assign memLock = (stateQ == ST_LOAD) || (stateQ == ST_STORE);

endmodule

// File: rtl/xchg_datapath.sv
module xchg_datapath
  import xchg_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  xchgStrobe_t   strobe,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqData,
  input  logic          reqByte,
  input  logic [DW-1:0] memRdata,
  output logic          reqMisaligned,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          memByte,
  output logic          rdWe,
  output logic [DW-1:0] rdData,
  output logic          alignFault,
  output logic          loadAbort,
  output logic          storeAbort
);

  localparam int LANES = DW / 8;
  localparam int OFFW  = $clog2(LANES);

  logic [AW-1:0] addrQ;
  logic [DW-1:0] dataQ;
  logic          byteQ;
  logic [DW-1:0] loadQ;
  logic          faultQ, loadAbQ, storeAbQ;
  logic [OFFW-1:0] offQ;
  logic [DW-1:0] rotated;

  assign reqMisaligned = !reqByte && (reqAddr[OFFW-1:0] != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      dataQ    <= '0;
      byteQ    <= 1'b0;
      loadQ    <= '0;
      faultQ   <= 1'b0;
      loadAbQ  <= 1'b0;
      storeAbQ <= 1'b0;
    end else begin
      if (strobe.captureReq) begin
        addrQ    <= reqAddr;
        dataQ    <= reqData;
        byteQ    <= reqByte;
        faultQ   <= strobe.markFault;
        loadAbQ  <= 1'b0;
        storeAbQ <= 1'b0;
      end
      if (strobe.captureLoad)    loadQ    <= memRdata;
      if (strobe.markLoadAbort)  loadAbQ  <= 1'b1;
      if (strobe.markStoreAbort) storeAbQ <= 1'b1;
    end
  end

  assign offQ = addrQ[OFFW-1:0];

  // Rotate right by whole bytes: output lane k takes source lane k+offset
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [OFFW-1:0] srcLane;
    assign srcLane = OFFW'(k) + offQ;
    assign rotated[k*8 +: 8] = loadQ[srcLane*8 +: 8];
  end

  assign memByte  = byteQ;
  assign memAddr  = byteQ ? addrQ : {addrQ[AW-1:OFFW], {OFFW{1'b0}}};
  assign memWdata = byteQ ? {{(DW-8){1'b0}}, dataQ[7:0]} : dataQ;

  assign rdData     = byteQ ? {{(DW-8){1'b0}}, loadQ[7:0]} : rotated;
  assign alignFault = faultQ;
  assign loadAbort  = loadAbQ;
  assign storeAbort = storeAbQ;
  assign rdWe       = strobe.finish && !faultQ && !loadAbQ && !storeAbQ;

endmodule

// File: rtl/atomic_xchg_unit.sv
module atomic_xchg_unit
  import xchg_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqData,
  input  logic          reqByte,
  input  logic          alignCheckEn,
  output logic          memReq,
  output logic          memWrite,
  output logic          memByte,
  output logic          memLock,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  input  logic          memReady,
  input  logic          memAbort,
  output logic          doneValid,
  output logic          rdWe,
  output logic [DW-1:0] rdData,
  output logic          alignFault,
  output logic          loadAbort,
  output logic          storeAbort
);

  xchgStrobe_t strobe;
  logic        reqMisaligned;

  xchg_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .alignCheckEn (alignCheckEn),
    .reqMisaligned(reqMisaligned),
    .memReady     (memReady),
    .memAbort     (memAbort),
    .reqReady     (reqReady),
    .memReq       (memReq),
    .memWrite     (memWrite),
    .memLock      (memLock),
    .doneValid    (doneValid),
    .strobe       (strobe)
  );

  xchg_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqAddr      (reqAddr),
    .reqData      (reqData),
    .reqByte      (reqByte),
    .memRdata     (memRdata),
    .reqMisaligned(reqMisaligned),
    .memAddr      (memAddr),
    .memWdata     (memWdata),
    .memByte      (memByte),
    .rdWe         (rdWe),
    .rdData       (rdData),
    .alignFault   (alignFault),
    .loadAbort    (loadAbort),
    .storeAbort   (storeAbort)
  );

endmodule

// File: rtl/xchg_checker.sv
module xchg_checker #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          reqReady,
  input logic [AW-1:0] reqAddr,
  input logic          reqByte,
  input logic          alignCheckEn,
  input logic          memReq,
  input logic          memWrite,
  input logic          memByte,
  input logic          memLock,
  input logic [AW-1:0] memAddr,
  input logic [DW-1:0] memWdata,
  input logic          memReady,
  input logic          memAbort,
  input logic          doneValid,
  input logic          rdWe,
  input logic          alignFault
);

  localparam int OFFW = $clog2(DW / 8);

  assert_store_follows_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWrite && memReady && !memAbort) |=> (memReq && memWrite && $stable(memAddr)));

  assert_word_addr_aligned_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memByte) |-> (memAddr[OFFW-1:0] == '0));

  assert_load_abort_no_store_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWrite && memReady && memAbort) |=> (!memReq && doneValid && !rdWe));

  assert_store_abort_no_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite && memReady && memAbort) |=> (doneValid && !rdWe));

  assert_align_fault_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqByte && alignCheckEn && (reqAddr[OFFW-1:0] != '0))
      |=> (doneValid && alignFault && !memReq && !rdWe));

  assert_lock_with_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memLock);

  assert_lock_off_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memLock);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWrite) && $stable(memWdata)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

endmodule

bind atomic_xchg_unit xchg_checker #(.AW(AW), .DW(DW)) u_xchgChecker (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .reqAddr     (reqAddr),
  .reqByte     (reqByte),
  .alignCheckEn(alignCheckEn),
  .memReq      (memReq),
  .memWrite    (memWrite),
  .memByte     (memByte),
  .memLock     (memLock),
  .memAddr     (memAddr),
  .memWdata    (memWdata),
  .memReady    (memReady),
  .memAbort    (memAbort),
  .doneValid   (doneValid),
  .rdWe        (rdWe),
  .alignFault  (alignFault)
);

// File: tb/atomic_xchg_unit_bench.sv
module atomic_xchg_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqData = '0;
  logic        reqByte = 1'b0;
  logic        alignCheckEn = 1'b0;
  logic        memReq, memWrite, memByte, memLock;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memReady = 1'b0;
  logic        memAbort = 1'b0;
  logic        doneValid, rdWe, alignFault, loadAbort, storeAbort;
  logic [31:0] rdData;

  always #5 clk = ~clk;

  atomic_xchg_unit u_atomic_xchg_unit (.*);

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit busy = 1'b0;
  bit finished = 1'b0;

  // memory model
  logic [31:0] memWords [int];
  int  cfgLat = 0;
  bit  injRd = 1'b0, injWr = 1'b0;
  int  waitCnt = 0;
  int  lastAck = 0;
  bit  logW[$];
  logic [31:0] logA[$];
  bit  logB[$];

  function automatic logic [31:0] getWord(int idx);
    if (memWords.exists(idx)) return memWords[idx];
    return {idx[15:0] ^ 16'h5A3C, ~idx[15:0]};
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // memory responder, acts at falling edges
  always @(negedge clk) begin
    if (memReady) begin
      memReady = 1'b0;
      memAbort = 1'b0;
    end else if (rstN && memReq) begin
      if (waitCnt < cfgLat) waitCnt++;
      else begin
        int idx;
        int lane;
        logic [31:0] w;
        waitCnt  = 0;
        memReady = 1'b1;
        memAbort = memWrite ? injWr : injRd;
        lastAck  = cyc;
        logW.push_back(memWrite);
        logA.push_back(memAddr);
        logB.push_back(memByte);
        idx  = int'(memAddr >> 2);
        lane = int'(memAddr[1:0]);
        w    = getWord(idx);
        if (!memWrite) begin
          memRdata = memByte ? {24'hA5C3E1, w[lane*8 +: 8]} : w;
        end else if (!memAbort) begin
          if (memByte) w[lane*8 +: 8] = memWdata[7:0];
          else         w = memWdata;
          memWords[idx] = w;
        end
      end
    end
  end

  // per-cycle comparison against the model state
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(memLock === memReq, "R8", "lock vs request", {31'b0, memLock}, {31'b0, memReq});
      check(reqReady === !busy, "R9", "ready vs busy", {31'b0, reqReady}, {31'b0, !busy});
    end
  end

  task automatic doSwap(input logic [31:0] a, input logic [31:0] d, input bit isByte,
                        input bit chk, input bit abRd, input bit abWr, input int lat,
                        input bit poke);
    bit expFault, expLa, expSa, expWe;
    logic [31:0] w, expRd, expMem, accAddr;
    int idx, w8, driveCyc, nExp;
    idx = int'(a >> 2);
    w = getWord(idx);
    expFault = !isByte && chk && (a[1:0] != 2'b00);
    expLa = !expFault && abRd;
    expSa = !expFault && !abRd && abWr;
    expWe = !expFault && !expLa && !expSa;
    if (isByte) expRd = {24'h0, w[a[1:0]*8 +: 8]};
    else begin
      logic [63:0] dbl;
      dbl = {w, w} >> (8 * a[1:0]);
      expRd = dbl[31:0];
    end
    expMem = w;
    if (expWe) begin
      if (isByte) expMem[a[1:0]*8 +: 8] = d[7:0];
      else expMem = d;
    end
    accAddr = isByte ? a : {a[31:2], 2'b00};
    nExp = expFault ? 0 : (abRd ? 1 : 2);
    logW.delete(); logA.delete(); logB.delete();
    cfgLat = lat; injRd = abRd; injWr = abWr;
    reqAddr = a; reqData = d; reqByte = isByte; alignCheckEn = chk; reqValid = 1'b1;
    driveCyc = cyc;
    @(posedge clk);
    busy = 1'b1;
    @(negedge clk);
    reqValid = poke;
    if (poke) begin reqAddr = a ^ 32'h40; reqData = ~d; end
    w8 = 0;
    while (!doneValid && w8 < 60) begin
      @(negedge clk);
      w8++;
      if (w8 >= 2) reqValid = 1'b0;
    end
    reqValid = 1'b0;
    check(doneValid === 1'b1, "R11", "completion seen", {31'b0, doneValid}, 32'd1);
    if (nExp == 0)
      check(cyc == driveCyc + 1, "R7", "fault completion cycle", cyc, driveCyc + 1);
    else
      check(cyc == lastAck + 1, "R11", "completion one cycle after last ack", cyc, lastAck + 1);
    check(rdWe === expWe, "R11", "register write enable", {31'b0, rdWe}, {31'b0, expWe});
    check(alignFault === expFault, "R7", "alignment flag", {31'b0, alignFault}, {31'b0, expFault});
    check(loadAbort === expLa, "R5", "load abort flag", {31'b0, loadAbort}, {31'b0, expLa});
    check(storeAbort === expSa, "R6", "store abort flag", {31'b0, storeAbort}, {31'b0, expSa});
    if (expWe) begin
      if (isByte) check(rdData === expRd, "R4", "byte result", rdData, expRd);
      else        check(rdData === expRd, "R2", "rotated word result", rdData, expRd);
    end
    check(logW.size() == nExp, "R1", "access count", logW.size(), nExp);
    if (logW.size() == nExp) begin
      for (int i = 0; i < nExp; i++) begin
        check(logW[i] == (i == 1), "R1", "access order", {31'b0, logW[i]}, i);
        check(logA[i] === accAddr, isByte ? "R4" : "R3", "access address", logA[i], accAddr);
        check(logB[i] == isByte, isByte ? "R4" : "R3", "access size", {31'b0, logB[i]}, {31'b0, isByte});
      end
    end
    check(getWord(idx) === expMem, abWr ? "R6" : (isByte ? "R4" : "R3"), "memory after swap", getWord(idx), expMem);
    @(posedge clk);
    busy = 1'b0;
    @(negedge clk);
    check(doneValid === 1'b0, "R11", "completion is one pulse", {31'b0, doneValid}, 32'd0);
    check(logW.size() == nExp, "R9", "no extra access", logW.size(), nExp);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(reqReady === 1'b1, "R10", "ready after reset", {31'b0, reqReady}, 32'd1);
    check(memReq === 1'b0 && memLock === 1'b0, "R10", "memory idle after reset", {30'b0, memReq, memLock}, 32'd0);
    check(doneValid === 1'b0 && rdWe === 1'b0, "R10", "no completion after reset", {30'b0, doneValid, rdWe}, 32'd0);

    doSwap(32'h0000_0100, 32'hCAFE_0001, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0); // aligned word
    doSwap(32'h0000_0100, 32'h1234_5678, 1'b0, 1'b1, 1'b0, 1'b0, 2, 1'b0); // reads previous store
    doSwap(32'h0000_0201, 32'h1111_2222, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1'b0); // R2 offset 1
    doSwap(32'h0000_0302, 32'h3333_4444, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0); // R2 offset 2
    doSwap(32'h0000_0403, 32'h5555_6666, 1'b0, 1'b0, 1'b0, 1'b0, 3, 1'b0); // R2 offset 3
    doSwap(32'h0000_0403, 32'h0BAD_F00D, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0); // R3 unrotated store
    doSwap(32'h0000_0503, 32'hFFFF_FF7E, 1'b1, 1'b1, 1'b0, 1'b0, 1, 1'b0); // R4 byte, check on
    doSwap(32'h0000_0500, 32'h0000_0081, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0); // R4 byte lane 0
    doSwap(32'h0000_0606, 32'h7777_8888, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b0); // R7 fault
    doSwap(32'h0000_0701, 32'h7777_8888, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b0); // R7 fault, offset 1
    doSwap(32'h0000_0800, 32'h9999_AAAA, 1'b0, 1'b0, 1'b1, 1'b0, 2, 1'b0); // R5 load abort
    doSwap(32'h0000_0900, 32'hBBBB_CCCC, 1'b0, 1'b0, 1'b0, 1'b1, 1, 1'b0); // R6 store abort
    doSwap(32'h0000_0A02, 32'h0000_00EE, 1'b1, 1'b0, 1'b0, 1'b1, 0, 1'b0); // R6 byte store abort
    doSwap(32'h0000_0B00, 32'hDDDD_EEEE, 1'b0, 1'b0, 1'b0, 1'b0, 4, 1'b1); // R9 request while busy
    doSwap(32'h0000_0B40, 32'h0101_0202, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0); // poke address untouched
    finishRun();
  end

endmodule